// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block is the master side of a two-wire serial bus engine, controlled through a small register port. Software arms one bus operation at a time by setting a single command bit (Start, Repeated Start, Stop, receive one byte, or send the acknowledge bit), or by writing a byte to the transmit register. The engine then drives the open-drain clock and data lines through the matching sequence. It clears the command bit when the sequence ends and returns to idle.

Each bit period is split into four quarter phases, and each quarter lasts a programmable number of clock cycles. Data changes only while the bus clock is low. Only the Start, Repeated Start and Stop conditions move the data line while the clock is high. After a sent byte, the engine samples the slave's acknowledge into a status bit. After a received byte, the byte lands in a read buffer and a full flag is raised. Nothing is queued: a command or a transmit write that arrives while the engine is busy is dropped.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00, both output enables are 0 (lines released), and the divider register (address 3) reads its reset value.
- R2: Writing 0x01 to address 0 while idle runs a Start: SDA falls while SCL is high. Bit 0 and busy (bit 7) read 1 during the sequence. Both clear after exactly 4 quarters, and SCL is left low.
- R3: Writing 0x04 to address 0 while idle runs a Stop: SDA rises while SCL is high, and both lines are released afterwards. It lasts 4 quarters.
- R4: Writing 0x02 to address 0 while idle runs a Repeated Start: SDA is released, SCL rises, then SDA falls while SCL is high. It lasts 4 quarters.
- R5: Writing a byte to address 1 while idle shifts it out MSB first over 8 SCL pulses, then a ninth pulse with SDA released. SDA never changes while SCL is high, and the whole transfer lasts 36 quarters.
- R6: Control bit 6 takes the SDA level sampled on the ninth pulse of a transmit: 0 means acknowledged, 1 means not acknowledged. It changes at no other time.
- R7: Writing 0x08 to address 0 while idle clocks in 8 bits, MSB first, sampled while SCL is high, over 32 quarters. The byte is then readable at address 2, and status bit 0 (buffer full) is set. A read of address 2 clears that flag.
- R8: Writing 0x10 to address 0 while idle sends one SCL pulse with SDA equal to control bit 5 (0 gives ACK, 1 gives NACK). Bit 5 is written by every control write, and the value written in the same write is the one sent.
- R9: While busy, control writes start no command and transmit writes are discarded. The running sequence completes unchanged.
- R10: A control write with more than one of bits 0 to 4 set starts nothing, but still updates bit 5.
- R11: A quarter lasts N clock cycles, where N is the value at address 3, and a value of 0 is treated as 1.
- R12: While the engine releases SCL and the line is still held low, quarter timing pauses. Each such cycle lengthens the sequence by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears buffer full on address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench pits commands against a busy engine. A design that queued or accepted such commands would show an extra Start or Stop on the bus, or a second byte in the captured bit stream. It sends an acknowledge command with the acknowledge value written in the same write, which catches a design that sends the stale register value. It runs random bytes at random divider values, including 0, and checks the exact busy length, so a shortened ninth pulse or a divider that is off by one changes the cycle count. A stretch test holds SCL low at the start of a Start. It exposes timing that runs on while the line is held low.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;

  // Operation codes: values 0..4 line up with control-register bits 0..4.
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_RECV   = 3'd3,
    OP_ACK    = 3'd4,
    OP_SEND   = 3'd5
  } op_t;

  localparam int CMD_N = 5;

  // Line levels {scl, sda} (1 = released) for quarter q of a bit of op.
  function automatic logic [1:0] quarter_lines(op_t op, logic [1:0] q, logic bitv);
    logic [1:0] r;
    case (op)
      OP_START:  r = (q == 2'd0) ? 2'b11 : (q == 2'd1) ? 2'b10 : 2'b00;
      OP_RSTART: r = (q == 2'd0) ? 2'b01 : (q == 2'd1) ? 2'b11 :
                     (q == 2'd2) ? 2'b10 : 2'b00;
      OP_STOP:   r = (q == 2'd0) ? 2'b00 : (q == 2'd1) ? 2'b10 : 2'b11;
      default:   r = {(q == 2'd1) || (q == 2'd2), bitv};
    endcase
    return r;
  endfunction

  // Number of bit periods an operation occupies.
  function automatic int bits_in(op_t op, int data_w);
    case (op)
      OP_SEND: return data_w + 1;
      OP_RECV: return data_w;
      default: return 1;
    endcase
  endfunction

  // Clock cycles per quarter for a divider value.
  function automatic int quarter_cycles(int div);
    return (div == 0) ? 1 : div;
  endfunction

  // Map a one-hot command field to its operation.
  function automatic op_t cmd_to_op(logic [CMD_N-1:0] c);
    if (c[0])      return OP_START;
    else if (c[1]) return OP_RSTART;
    else if (c[2]) return OP_STOP;
    else if (c[3]) return OP_RECV;
    else           return OP_ACK;
  endfunction

endpackage

// File: rtl/i2c_cs_quarter.sv
module i2c_cs_quarter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = (div == '0) ? '0 : div - 1'b1;
  assign tick     = run && !hold && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (!hold)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_cs_engine.sv
module i2c_cs_engine
  import i2c_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_t               launch_op,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ack_bit,
  input  logic              tick,
  input  logic              sda_in,
  output logic              busy,
  output op_t               run_op,
  output logic              scl_lvl,
  output logic              sda_lvl,
  output logic              ack_status,
  output logic              sample_evt,
  output logic              ack_sample,
  output logic              seq_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  op_t               op_q;
  logic [1:0]        q_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              busy_q, scl_q, sda_q, ack_q;
  logic              last_bit;
  logic [DATA_W-1:0] launch_sh;

  // Bit value driven during bit idx of an operation (1 = released).
  function automatic logic pick_bit(op_t o, logic [DATA_W-1:0] sh, int idx);
    int k;
    k = (idx < DATA_W) ? (DATA_W - 1 - idx) : 0;
    if (o == OP_SEND)     return (idx < DATA_W) ? sh[k] : 1'b1;
    else if (o == OP_ACK) return sh[DATA_W-1];
    else                  return 1'b1;
  endfunction

  assign launch_sh  = (launch_op == OP_ACK) ? {ack_bit, {(DATA_W-1){1'b0}}} : tx_byte;
  assign last_bit   = (int'(bit_q) == bits_in(op_q, DATA_W) - 1);
  assign sample_evt = busy_q && tick && (q_q == 2'd1);
  assign ack_sample = sample_evt && (op_q == OP_SEND) && (int'(bit_q) == DATA_W);
  assign seq_done   = busy_q && tick && (q_q == 2'd3) && last_bit;
  assign rx_done    = seq_done && (op_q == OP_RECV);
  assign rx_byte    = sh_q;

  assign busy       = busy_q;
  assign run_op     = op_q;
  assign scl_lvl    = scl_q;
  assign sda_lvl    = sda_q;
  assign ack_status = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_START;
      q_q    <= 2'd0;
      bit_q  <= '0;
      sh_q   <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ack_q  <= 1'b0;
    end else if (launch && !busy_q) begin
      busy_q         <= 1'b1;
      op_q           <= launch_op;
      q_q            <= 2'd0;
      bit_q          <= '0;
      sh_q           <= launch_sh;
      {scl_q, sda_q} <= quarter_lines(launch_op, 2'd0, pick_bit(launch_op, launch_sh, 0));
    end else if (busy_q && tick) begin
      if (sample_evt && op_q == OP_RECV) sh_q <= {sh_q[DATA_W-2:0], sda_in};
      if (ack_sample) ack_q <= sda_in;
      if (q_q == 2'd3) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q          <= bit_q + 1'b1;
          q_q            <= 2'd0;
          {scl_q, sda_q} <= quarter_lines(op_q, 2'd0, pick_bit(op_q, sh_q, int'(bit_q) + 1));
        end
      end else begin
        q_q            <= q_q + 2'd1;
        {scl_q, sda_q} <= quarter_lines(op_q, q_q + 2'd1, pick_bit(op_q, sh_q, int'(bit_q)));
      end
    end
  end
endmodule

// File: rtl/i2c_cs_regs.sv
module i2c_cs_regs
  import i2c_cs_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  op_t               run_op,
  input  logic              ack_status,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              launch,
  output op_t               launch_op,
  output logic              ack_bit,
  output logic              rx_full,
  output logic [DIV_W-1:0]  div
);
  localparam logic [1:0] A_CTRL = 2'd0, A_TX = 2'd1, A_RX = 2'd2, A_DIV = 2'd3;

  logic              ctrl_wr, tx_wr, cmd_ok;
  logic [CMD_N-1:0]  cmd_field, cmd_bits;
  logic              ack_data_q, rx_full_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        ctrl_view;

  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign tx_wr     = reg_wr && (reg_addr == A_TX);
  assign cmd_field = reg_wdata[CMD_N-1:0];
  assign cmd_ok    = $onehot(cmd_field);
  assign launch    = !busy && ((ctrl_wr && cmd_ok) || tx_wr);
  assign launch_op = tx_wr ? OP_SEND : cmd_to_op(cmd_field);
  assign ack_bit   = ctrl_wr ? reg_wdata[5] : ack_data_q;
  assign rx_full   = rx_full_q;
  assign div       = div_q;

  for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
    assign cmd_bits[i] = busy && (run_op == op_t'(i));
  end

  assign ctrl_view = {busy, ack_status, ack_data_q, cmd_bits};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_view);
      A_TX:    reg_rdata = DATA_W'(rx_full_q);
      A_RX:    reg_rdata = rx_buf_q;
      default: reg_rdata = DATA_W'(div_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_data_q <= 1'b0;
      rx_full_q  <= 1'b0;
      rx_buf_q   <= '0;
      div_q      <= DIV_RESET;
    end else begin
      if (ctrl_wr) ack_data_q <= reg_wdata[5];
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (rx_done) begin
        rx_buf_q  <= rx_byte;
        rx_full_q <= 1'b1;
      end else if (reg_rd && reg_addr == A_RX) begin
        rx_full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cs_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  // Named internal events, also observed by the bound checker.
  logic              accept_go, busy, tick, hold;
  logic              scl_lvl, sda_lvl, ack_status, ack_bit;
  logic              sample_evt, ack_sample, seq_done, rx_done, rx_full;
  logic [DATA_W-1:0] rx_byte;
  logic [DIV_W-1:0]  div;
  op_t               launch_op, run_op;

  assign hold   = scl_lvl && !scl_in;
  assign scl_oe = !scl_lvl;
  assign sda_oe = !sda_lvl;

  i2c_cs_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .run_op(run_op), .ack_status(ack_status),
    .rx_done(rx_done), .rx_byte(rx_byte), .launch(accept_go),
    .launch_op(launch_op), .ack_bit(ack_bit), .rx_full(rx_full), .div(div)
  );

  i2c_cs_quarter #(.DIV_W(DIV_W)) u_quarter (
    .clk(clk), .rst_n(rst_n), .run(busy), .hold(hold), .div(div), .tick(tick)
  );

  i2c_cs_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch(accept_go), .launch_op(launch_op),
    .tx_byte(reg_wdata), .ack_bit(ack_bit), .tick(tick), .sda_in(sda_in),
    .busy(busy), .run_op(run_op), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .ack_status(ack_status), .sample_evt(sample_evt), .ack_sample(ack_sample),
    .seq_done(seq_done), .rx_done(rx_done), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/i2c_cs_checker.sv
module i2c_cs_checker
  import i2c_cs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic accept_go,
  input logic busy,
  input logic seq_done,
  input op_t  run_op,
  input logic scl_lvl,
  input logic sda_lvl,
  input logic ack_status,
  input logic ack_sample,
  input logic rx_done,
  input logic rx_full
);
  logic data_op;
  assign data_op = (run_op == OP_SEND) || (run_op == OP_RECV) || (run_op == OP_ACK);

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_go |-> !busy);

  assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);

  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && run_op == OP_STOP) |=> (scl_lvl && sda_lvl));

  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && data_op && scl_lvl && $past(scl_lvl)) |-> $stable(sda_lvl));

  assert_ack_only_ninth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_status) |-> $past(ack_sample));

  assert_full_from_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done));
endmodule

bind i2c_cond_seq i2c_cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .accept_go(accept_go), .busy(busy),
  .seq_done(seq_done), .run_op(run_op), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
  .ack_status(ack_status), .ack_sample(ack_sample), .rx_done(rx_done),
  .rx_full(rx_full)
);

// File: tb/sim_i2c_cond_seq.sv
`timescale 1ns/1ps
module sim_i2c_cond_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, scl_in, sda_in;
  logic       stretch = 1'b0, slv_pull = 1'b0, slv_en = 1'b0;
  logic [8:0] resp = 9'h1FF;
  int         fall_base = 0;

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  // Bus monitor state
  int          n_start = 0, n_stop = 0, n_cap = 0, n_fall = 0;
  logic [31:0] cap = '0;
  logic        p_scl = 1'b1, p_sda = 1'b1;

  always #4 clk = ~clk;

  assign scl_in = !scl_oe && !stretch;
  assign sda_in = !sda_oe && !slv_pull;

  i2c_cond_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always @(negedge clk) begin
    if (scl_in && p_scl && p_sda && !sda_in) n_start++;
    if (scl_in && p_scl && !p_sda && sda_in) n_stop++;
    if (scl_in && !p_scl) begin cap = {cap[30:0], sda_in}; n_cap++; end
    if (!scl_in && p_scl) n_fall++;
    p_scl = scl_in;
    p_sda = sda_in;
    if (slv_en && (n_fall - fall_base) < 9) slv_pull = !resp[8 - (n_fall - fall_base)];
    else slv_pull = 1'b0;
  end

  function automatic int exp_len(int bits, int div);
    return bits * 4 * ((div == 0) ? 1 : div);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = (a == 2'd2);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = 2'd0;
    #1;
    while (reg_rdata[7]) begin n++; @(negedge clk); #1; end
  endtask

  task automatic do_tx(input logic [7:0] b, input logic ackv, input int div, input string tag);
    int n, s0, c0;
    logic [7:0] r;
    resp = {8'hFF, ackv}; fall_base = n_fall; slv_en = 1'b1;
    s0 = n_start + n_stop; c0 = n_cap;
    wr(2'd1, b);
    wait_idle(n);
    check(n == exp_len(9, div), {tag, " R5 tx length"}, n, exp_len(9, div));
    check(cap[8:1] == b, {tag, " R5 tx bits"}, int'(cap[8:1]), int'(b));
    check(n_cap - c0 == 9, {tag, " R5 pulse count"}, n_cap - c0, 9);
    check(n_start + n_stop == s0, {tag, " R5 no sda edge with scl high"}, n_start + n_stop, s0);
    @(negedge clk); rd(2'd0, r);
    check(r[6] == ackv, {tag, " R6 ack status"}, int'(r[6]), int'(ackv));
    slv_en = 1'b0;
  endtask

  task automatic do_rx(input logic [7:0] b, input int div, input string tag);
    int n;
    logic [7:0] r;
    resp = {b, 1'b1}; fall_base = n_fall; slv_en = 1'b1;
    wr(2'd0, 8'h08);
    wait_idle(n);
    check(n == exp_len(8, div), {tag, " R7 rx length"}, n, exp_len(8, div));
    @(negedge clk); rd(2'd1, r);
    check(r == 8'h01, {tag, " R7 full set"}, int'(r), 1);
    rd(2'd2, r);
    check(r == b, {tag, " R7 rx byte"}, int'(r), int'(b));
    rd(2'd1, r);
    check(r == 8'h00, {tag, " R7 full cleared"}, int'(r), 0);
    slv_en = 1'b0;
  endtask

  task automatic do_ack(input logic a, input int div, input string tag);
    int n, c0;
    c0 = n_cap;
    wr(2'd0, {2'b00, a, 5'b10000});
    wait_idle(n);
    check(n == exp_len(1, div), {tag, " R8 ack length"}, n, exp_len(1, div));
    check(cap[0] == a && n_cap - c0 == 1, {tag, " R8 ack level"}, int'(cap[0]), int'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n, s0, p0, c0, seed, div;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); check(r == 8'h00, "R1 ctrl", int'(r), 0);
    rd(2'd1, r); check(r == 8'h00, "R1 status", int'(r), 0);
    rd(2'd3, r); check(r == 8'd4, "R1 divider", int'(r), 4);
    check(!scl_oe && !sda_oe, "R1 lines released", int'({scl_oe, sda_oe}), 0);

    // R2 start from idle
    s0 = n_start;
    wr(2'd0, 8'h01);
    rd(2'd0, r);
    check(r == 8'h81, "R2 start bit and busy", int'(r), 8'h81);
    wait_idle(n);
    check(n == exp_len(1, 4) - 1, "R2 start length", n, exp_len(1, 4) - 1);
    check(n_start == s0 + 1, "R2 start seen", n_start, s0 + 1);
    rd(2'd0, r);
    check(r[4:0] == 5'd0 && r[7] == 1'b0, "R2 bits cleared", int'(r), 0);
    check(scl_oe == 1'b1, "R2 scl held low", int'(scl_oe), 1);

    do_tx(8'hA5, 1'b0, 4, "dir");
    do_tx(8'h3C, 1'b1, 4, "dir");

    // R4 repeated start
    s0 = n_start;
    wr(2'd0, 8'h02); wait_idle(n);
    check(n == exp_len(1, 4), "R4 rstart length", n, exp_len(1, 4));
    check(n_start == s0 + 1, "R4 rstart seen", n_start, s0 + 1);

    do_rx(8'hC3, 4, "dir");
    do_ack(1'b1, 4, "dir");
    do_ack(1'b0, 4, "dir");

    // R3 stop
    p0 = n_stop;
    wr(2'd0, 8'h04); wait_idle(n);
    check(n == exp_len(1, 4), "R3 stop length", n, exp_len(1, 4));
    check(n_stop == p0 + 1, "R3 stop seen", n_stop, p0 + 1);
    check(!scl_oe && !sda_oe, "R3 lines released", int'({scl_oe, sda_oe}), 0);

    // R10 multi-bit command ignored, ack data still written
    s0 = n_start; p0 = n_stop;
    wr(2'd0, 8'h25);
    rd(2'd0, r);
    check((r & 8'hBF) == 8'h20, "R10 nothing started, bit5 set", int'(r & 8'hBF), 8'h20);
    check(n_start == s0 && n_stop == p0, "R10 bus quiet", n_start + n_stop, s0 + p0);

    // R12 clock stretch on a start
    stretch = 1'b1;
    s0 = n_start;
    wr(2'd0, 8'h01);
    repeat (7) @(negedge clk);
    stretch = 1'b0;
    wait_idle(n);
    check(n + 7 == exp_len(1, 4) + 7, "R12 stretched length", n + 7, exp_len(1, 4) + 7);
    check(n_start == s0 + 1, "R12 start after stretch", n_start, s0 + 1);

    // R9 commands and tx writes during busy are dropped
    p0 = n_stop; s0 = n_start; c0 = n_cap;
    resp = 9'h1FE; fall_base = n_fall; slv_en = 1'b1;
    wr(2'd1, 8'h96);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h01);
    wait_idle(n);
    slv_en = 1'b0;
    check(cap[8:1] == 8'h96, "R9 first byte kept", int'(cap[8:1]), 8'h96);
    check(n_cap - c0 == 9, "R9 no second byte", n_cap - c0, 9);
    check(n_stop == p0 && n_start == s0, "R9 no condition", n_stop + n_start, p0 + s0);
    repeat (4 * 9 * 4) @(negedge clk);
    rd(2'd0, r);
    check(r[7] == 1'b0, "R9 still idle", int'(r[7]), 0);

    // R11 divider value 0 acts as 1
    wr(2'd3, 8'd0);
    do_tx(8'h81, 1'b0, 0, "R11 div0");

    // Random mix
    for (int i = 0; i < 12; i++) begin
      div = 1 + ($urandom % 6);
      wr(2'd3, div[7:0]);
      do_tx($urandom, $urandom % 2, div, "R11 rnd");
      do_rx($urandom, div, "R11 rnd");
      do_ack($urandom % 2, div, "R11 rnd");
    end

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule